// File: doc/BRIEF.md
# Message Object Completion and Transmit Arbitration

This block keeps the bookkeeping for a bank of message objects inside a CAN-style controller. Each object carries an enable bit, a role (transmitter or receiver), an expected data length, an interrupt enable and an eight-bit status register. Whenever the frame engine reports that it is idle, the block picks the enabled transmitter with the lowest index and hands that choice to the engine as a grant. The grant does not change until the engine reports idle again.

The frame engine appears here only as event inputs: transmit completion, reception at the sixth end-of-frame bit together with an acceptance-hit vector and the received length code, and the individual protocol errors. A completion sets the matching flag and disarms the object. A reception also stores the received length and warns when that length differs from the one that was configured. Flags stay set until software writes back the whole status register. An interrupt output combines every flag of every object that has its interrupt enabled.

Top module: `msgobj_ctrl`

## Requirements
- R1: After reset every object is disabled, has length 0, all status bits 0 and interrupt enable 0; `grant_valid` and `irq` are 0.
- R2: A configuration write (`cfg_we`) loads enable, role (`cfg_is_tx`=1 means transmitter), length and interrupt enable of object `cfg_idx` at the next edge, and takes priority over a hardware update of the same object's enable or length in that cycle.
- R3: In each cycle where `eng_idle` is 1, the next edge loads `grant_valid`/`grant_idx` with the lowest-index object that is enabled and a transmitter; if there is none, `grant_valid` becomes 0.
- R4: While `eng_idle` is 0, `grant_valid` and `grant_idx` keep their values.
- R5: A `tx_done` pulse while `grant_valid` is 1 sets status bit 6 (transmit OK) of the granted object and clears its enable at the next edge.
- R6: An `rx_eof6` pulse updates only the lowest-index object that is hit in `rx_hit`, enabled and a receiver: status bit 5 (receive OK) sets, the enable clears and the stored length takes `rx_len`. Every other object is left unchanged.
- R7: On that update, status bit 7 (length warning) sets if `rx_len` differs from the length stored before the update.
- R8: While `grant_valid` is 1, `bit_mismatch` sets status bit 4 of the granted object, except when `in_arbitration` and `sent_recessive` are both 1 or when `errframe_ack` is 1.
- R9: While `grant_valid` is 1, `stuff_err`, `crc_err`, `form_err` and `ack_err` set status bits 3, 2, 1 and 0 of the granted object.
- R10: A status write (`st_we`) replaces the status of object `st_idx` with `st_data`. A flag that hardware sets in the same cycle still ends up set.
- R11: `irq` is 1 exactly when some object has its interrupt enable set and at least one status bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Object index for configuration |
| cfg_enable | input | 1 | Enable value to load |
| cfg_is_tx | input | 1 | Role: 1 transmitter, 0 receiver |
| cfg_len | input | 4 | Expected length code |
| cfg_irq_en | input | 1 | Interrupt enable value |
| st_we | input | 1 | Status write strobe |
| st_idx | input | 4 | Object index for status write |
| st_data | input | 8 | New status value |
| eng_idle | input | 1 | Frame engine idle; arbitration allowed |
| grant_valid | output | 1 | A transmitter is granted |
| grant_idx | output | 4 | Granted object index |
| tx_done | input | 1 | Transmission finished at end of end-of-frame |
| bit_mismatch | input | 1 | Monitored bit differs from sent bit |
| sent_recessive | input | 1 | The mismatched bit was sent recessive |
| in_arbitration | input | 1 | Mismatch occurred in the arbitration field |
| errframe_ack | input | 1 | Mismatch is a dominant ack slot seen while sending an error frame |
| stuff_err | input | 1 | Stuffing error event |
| crc_err | input | 1 | CRC error event |
| form_err | input | 1 | Form error event |
| ack_err | input | 1 | Acknowledge error event |
| rx_eof6 | input | 1 | Received frame reached sixth end-of-frame bit |
| rx_hit | input | 15 | Acceptance hit per object |
| rx_len | input | 4 | Received length code |
| rd_idx | input | 4 | Object index to read |
| rd_status | output | 8 | Status of object `rd_idx` |
| rd_len | output | 4 | Stored length of object `rd_idx` |
| rd_enable | output | 1 | Enable of object `rd_idx` |
| rd_is_tx | output | 1 | Role of object `rd_idx` |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench drives several enabled transmitters at once and enables a lower-index one in the middle of a frame. A wrong priority order shows up as the wrong grant, and a missing hold shows up as a grant that moves before idle. A received frame that hits several receivers is checked to update only the lowest one, so a design that updates every hit, or updates a disabled or transmitting object, leaves extra flags or wrong lengths behind. The bench also covers both bit-error exclusions, an equal length code (no warning) next to a differing one, and a status write in the same cycle as a hardware set, where a clear-wins design would lose the flag.

// File: rtl/msgobj_pkg.sv
`timescale 1ns/1ps
package msgobj_pkg;
   localparam int FLAG_W    = 8;
   localparam int F_LENWARN = 7;
   localparam int F_TXOK    = 6;
   localparam int F_RXOK    = 5;
   localparam int F_BITE    = 4;
   localparam int F_STUFFE  = 3;
   localparam int F_CRCE    = 2;
   localparam int F_FORME   = 1;
   localparam int F_ACKE    = 0;
   localparam int ERR_W     = 5;

   typedef logic [FLAG_W-1:0] flags_t;
   typedef logic [ERR_W-1:0]  errs_t;
endpackage

// File: rtl/msgobj_lowpick.sv
`timescale 1ns/1ps
module msgobj_lowpick #(
   parameter int N      = 15,
   parameter int IDX_W  = 4,
   parameter bit CHAIN  = 1'b1
) (
   input  logic [N-1:0]     req,
   output logic             found,
   output logic [N-1:0]     onehot,
   output logic [IDX_W-1:0] idx
);
   if (N < 1 || N > (1 << IDX_W)) begin : g_bad_cfg
      $error("msgobj_lowpick: N does not fit IDX_W");
   end

   if (CHAIN) begin : g_chain
      logic [N:0] blocked;
      assign blocked[0] = 1'b0;
      for (genvar i = 0; i < N; i++) begin : g_bit
         assign onehot[i]    = req[i] & ~blocked[i];
         assign blocked[i+1] = blocked[i] | req[i];
      end
   end else begin : g_loop
      always_comb begin
         onehot = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) onehot = N'(1) << i;
         end
      end
   end

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (onehot[i]) idx = idx | IDX_W'(i);
      end
   end

   assign found = |req;
endmodule

// File: rtl/msgobj_slot.sv
`timescale 1ns/1ps
module msgobj_slot
   import msgobj_pkg::*;
#(
   parameter int LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic             cfg_enable,
   input  logic             cfg_is_tx,
   input  logic [LEN_W-1:0] cfg_len,
   input  logic             cfg_irq_en,
   input  logic             st_we,
   input  flags_t           st_data,
   input  logic             tx_hit,
   input  logic             rx_hit,
   input  logic [LEN_W-1:0] rx_len,
   input  errs_t            err_set,
   output logic             en_q,
   output logic             is_tx_q,
   output logic [LEN_W-1:0] len_q,
   output logic             ie_q,
   output flags_t           st_q
);
   flags_t set_v;
   flags_t st_n;

   always_comb begin
      set_v            = '0;
      set_v[F_LENWARN] = rx_hit && (rx_len != len_q);
      set_v[F_TXOK]    = tx_hit;
      set_v[F_RXOK]    = rx_hit;
      set_v[F_BITE]    = err_set[4];
      set_v[F_STUFFE]  = err_set[3];
      set_v[F_CRCE]    = err_set[2];
      set_v[F_FORME]   = err_set[1];
      set_v[F_ACKE]    = err_set[0];
      st_n = (st_we ? st_data : st_q) | set_v;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         is_tx_q <= 1'b0;
         len_q   <= '0;
         ie_q    <= 1'b0;
         st_q    <= '0;
      end else begin
         st_q <= st_n;
         if (cfg_we) begin
            en_q    <= cfg_enable;
            is_tx_q <= cfg_is_tx;
            len_q   <= cfg_len;
            ie_q    <= cfg_irq_en;
         end else begin
            if (tx_hit || rx_hit) en_q <= 1'b0;
            if (rx_hit) len_q <= rx_len;
         end
      end
   end

   assert_txok_disarm_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_hit && !cfg_we) |=> (st_q[F_TXOK] && !en_q));
   assert_rxok_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_hit && !cfg_we) |=> (st_q[F_RXOK] && !en_q && len_q == $past(rx_len)));
   assert_lenwarn_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_hit && rx_len != len_q) |=> st_q[F_LENWARN]);
   assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_we && tx_hit) |=> st_q[F_TXOK]);
endmodule

// File: rtl/msgobj_txarb.sv
`timescale 1ns/1ps
module msgobj_txarb #(
   parameter int N     = 15,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             eng_idle,
   input  logic [N-1:0]     tx_req,
   output logic             grant_valid,
   output logic [IDX_W-1:0] grant_idx
);
   logic             pick_found;
   logic [N-1:0]     pick_oh;
   logic [IDX_W-1:0] pick_idx;

   msgobj_lowpick #(.N(N), .IDX_W(IDX_W), .CHAIN(1'b1)) u_pick (
      .req    (tx_req),
      .found  (pick_found),
      .onehot (pick_oh),
      .idx    (pick_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_valid <= 1'b0;
         grant_idx   <= '0;
      end else if (eng_idle) begin
         grant_valid <= pick_found;
         grant_idx   <= pick_idx;
      end
   end

   assert_grant_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_idle |=> ($stable(grant_valid) && $stable(grant_idx)));
   assert_pick_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pick_oh) && ((pick_oh & ~tx_req) == '0));
endmodule

// File: rtl/msgobj_ctrl.sv
`timescale 1ns/1ps
module msgobj_ctrl
   import msgobj_pkg::*;
#(
   parameter int N     = 15,
   parameter int IDX_W = 4,
   parameter int LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [IDX_W-1:0] cfg_idx,
   input  logic             cfg_enable,
   input  logic             cfg_is_tx,
   input  logic [LEN_W-1:0] cfg_len,
   input  logic             cfg_irq_en,
   input  logic             st_we,
   input  logic [IDX_W-1:0] st_idx,
   input  logic [7:0]       st_data,
   input  logic             eng_idle,
   output logic             grant_valid,
   output logic [IDX_W-1:0] grant_idx,
   input  logic             tx_done,
   input  logic             bit_mismatch,
   input  logic             sent_recessive,
   input  logic             in_arbitration,
   input  logic             errframe_ack,
   input  logic             stuff_err,
   input  logic             crc_err,
   input  logic             form_err,
   input  logic             ack_err,
   input  logic             rx_eof6,
   input  logic [N-1:0]     rx_hit,
   input  logic [LEN_W-1:0] rx_len,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [7:0]       rd_status,
   output logic [LEN_W-1:0] rd_len,
   output logic             rd_enable,
   output logic             rd_is_tx,
   output logic             irq
);
   if (N < 1 || N > (1 << IDX_W)) begin : g_bad_n
      $error("msgobj_ctrl: N does not fit IDX_W");
   end
   if (LEN_W < 1) begin : g_bad_len
      $error("msgobj_ctrl: LEN_W must be positive");
   end

   logic [N-1:0]     en_v, tx_v, ie_v, flag_any;
   logic [LEN_W-1:0] len_a [N];
   flags_t           st_a  [N];

   logic [N-1:0]     rx_cand, rx_sel, tx_sel;
   logic             rx_found;
   logic [IDX_W-1:0] rx_idx;
   logic             bite_q;
   errs_t            err_v;

   msgobj_txarb #(.N(N), .IDX_W(IDX_W)) u_arb (
      .clk         (clk),
      .rst_n       (rst_n),
      .eng_idle    (eng_idle),
      .tx_req      (en_v & tx_v),
      .grant_valid (grant_valid),
      .grant_idx   (grant_idx)
   );

   assign rx_cand = rx_eof6 ? (rx_hit & en_v & ~tx_v) : '0;

   msgobj_lowpick #(.N(N), .IDX_W(IDX_W), .CHAIN(1'b0)) u_rxpick (
      .req    (rx_cand),
      .found  (rx_found),
      .onehot (rx_sel),
      .idx    (rx_idx)
   );

   assign bite_q = bit_mismatch && !(in_arbitration && sent_recessive) && !errframe_ack;
   assign err_v  = {bite_q, stuff_err, crc_err, form_err, ack_err};

   for (genvar i = 0; i < N; i++) begin : g_obj
      logic own_grant;
      assign own_grant = grant_valid && (grant_idx == IDX_W'(i));
      assign tx_sel[i] = own_grant && tx_done;

      msgobj_slot #(.LEN_W(LEN_W)) u_slot (
         .clk        (clk),
         .rst_n      (rst_n),
         .cfg_we     (cfg_we && cfg_idx == IDX_W'(i)),
         .cfg_enable (cfg_enable),
         .cfg_is_tx  (cfg_is_tx),
         .cfg_len    (cfg_len),
         .cfg_irq_en (cfg_irq_en),
         .st_we      (st_we && st_idx == IDX_W'(i)),
         .st_data    (st_data),
         .tx_hit     (tx_sel[i]),
         .rx_hit     (rx_sel[i]),
         .rx_len     (rx_len),
         .err_set    (own_grant ? err_v : '0),
         .en_q       (en_v[i]),
         .is_tx_q    (tx_v[i]),
         .len_q      (len_a[i]),
         .ie_q       (ie_v[i]),
         .st_q       (st_a[i])
      );
      assign flag_any[i] = |st_a[i];
   end

   assign irq = |(flag_any & ie_v);

   always_comb begin
      rd_status = '0;
      rd_len    = '0;
      rd_enable = 1'b0;
      rd_is_tx  = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (rd_idx == IDX_W'(i)) begin
            rd_status = st_a[i];
            rd_len    = len_a[i];
            rd_enable = en_v[i];
            rd_is_tx  = tx_v[i];
         end
      end
   end

   assert_rx_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rx_sel) && (rx_found == (rx_sel != '0)));
   assert_rx_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_found |-> (rx_hit[rx_idx] && en_v[rx_idx] && !tx_v[rx_idx]));
   assert_berr_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && !cfg_we && !st_we && errframe_ack && !st_a[grant_idx][4])
         |=> !st_a[$past(grant_idx)][4]);
   assert_tx_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tx_sel));
endmodule

// File: tb/msgobj_ctrl_tb_top.sv
`timescale 1ns/1ps
module msgobj_ctrl_tb_top;
   localparam int N = 15;
   localparam int WATCH_CYC = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic       cfg_we, cfg_enable, cfg_is_tx, cfg_irq_en;
   logic [3:0] cfg_idx, cfg_len;
   logic       st_we;
   logic [3:0] st_idx;
   logic [7:0] st_data;
   logic       eng_idle, grant_valid;
   logic [3:0] grant_idx;
   logic       tx_done, bit_mismatch, sent_recessive, in_arbitration, errframe_ack;
   logic       stuff_err, crc_err, form_err, ack_err;
   logic       rx_eof6;
   logic [N-1:0] rx_hit;
   logic [3:0] rx_len, rd_idx, rd_len;
   logic [7:0] rd_status;
   logic       rd_enable, rd_is_tx, irq;

   msgobj_ctrl dut_i (.*);

   int checks = 0;
   int errors = 0;

   bit       m_en [N];
   bit       m_tx [N];
   bit [3:0] m_len[N];
   bit       m_ie [N];
   bit [7:0] m_st [N];
   bit       m_gv;
   int       m_gi;
   bit       prev_idle;

   string bit_tag [8] = '{"R9", "R9", "R9", "R9", "R8", "R6", "R5", "R7"};

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic clear_inputs();
      cfg_we = 0; cfg_idx = 0; cfg_enable = 0; cfg_is_tx = 0; cfg_len = 0; cfg_irq_en = 0;
      st_we = 0; st_idx = 0; st_data = 0;
      tx_done = 0; bit_mismatch = 0; sent_recessive = 0; in_arbitration = 0; errframe_ack = 0;
      stuff_err = 0; crc_err = 0; form_err = 0; ack_err = 0;
      rx_eof6 = 0; rx_hit = '0; rx_len = 0;
   endtask

   function automatic int low_tx();
      for (int i = 0; i < N; i++) if (m_en[i] && m_tx[i]) return i;
      return -1;
   endfunction

   function automatic bit model_irq();
      for (int i = 0; i < N; i++) if (m_ie[i] && m_st[i] != 0) return 1'b1;
      return 1'b0;
   endfunction

   task automatic model_update();
      int rxs = -1;
      int txs;
      int ng;
      bit [4:0] e = '0;
      if (rx_eof6)
         for (int i = N - 1; i >= 0; i--)
            if (rx_hit[i] && m_en[i] && !m_tx[i]) rxs = i;
      txs = (tx_done && m_gv) ? m_gi : -1;
      if (m_gv) e = {bit_mismatch && !(in_arbitration && sent_recessive) && !errframe_ack,
                     stuff_err, crc_err, form_err, ack_err};
      ng = low_tx();
      for (int i = 0; i < N; i++) begin
         bit [7:0] s = '0;
         bit [7:0] base;
         if (i == txs) s[6] = 1;
         if (i == rxs) begin s[5] = 1; if (rx_len != m_len[i]) s[7] = 1; end
         if (m_gv && i == m_gi) s[4:0] = e;
         base = (st_we && st_idx == 4'(i)) ? st_data : m_st[i];
         m_st[i] = base | s;
         if (cfg_we && cfg_idx == 4'(i)) begin
            m_en[i] = cfg_enable; m_tx[i] = cfg_is_tx; m_len[i] = cfg_len; m_ie[i] = cfg_irq_en;
         end else begin
            if (i == txs || i == rxs) m_en[i] = 0;
            if (i == rxs) m_len[i] = rx_len;
         end
      end
      prev_idle = eng_idle;
      if (eng_idle) begin
         m_gv = (ng >= 0);
         m_gi = (ng >= 0) ? ng : 0;
      end
   endtask

   task automatic check_all();
      string gtag;
      gtag = prev_idle ? "R3" : "R4";
      chk(grant_valid == m_gv, gtag, "grant_valid", int'(grant_valid), int'(m_gv));
      if (m_gv) chk(grant_idx == 4'(m_gi), gtag, "grant_idx", int'(grant_idx), m_gi);
      chk(irq == model_irq(), "R11", "irq", int'(irq), int'(model_irq()));
      for (int i = 0; i < N; i++) begin
         rd_idx = 4'(i);
         #0.05;
         chk(rd_enable == m_en[i], "R2", $sformatf("enable obj %0d", i), int'(rd_enable), int'(m_en[i]));
         chk(rd_is_tx == m_tx[i], "R2", $sformatf("role obj %0d", i), int'(rd_is_tx), int'(m_tx[i]));
         chk(rd_len == m_len[i], "R6", $sformatf("len obj %0d", i), int'(rd_len), int'(m_len[i]));
         for (int b = 0; b < 8; b++)
            if (rd_status[b] != m_st[i][b])
               chk(1'b0, bit_tag[b], $sformatf("status obj %0d bit %0d", i, b),
                   int'(rd_status[b]), int'(m_st[i][b]));
         chk(rd_status == m_st[i], "R10", $sformatf("status obj %0d", i), int'(rd_status), int'(m_st[i]));
      end
   endtask

   task automatic step();
      model_update();
      @(posedge clk);
      #1;
      check_all();
      @(negedge clk);
      clear_inputs();
   endtask

   task automatic read_obj(input int i);
      rd_idx = 4'(i);
      #0.05;
   endtask

   task automatic cfg(input int i, input bit en, input bit tx, input int len, input bit ie);
      cfg_we = 1; cfg_idx = 4'(i); cfg_enable = en; cfg_is_tx = tx; cfg_len = 4'(len); cfg_irq_en = ie;
      step();
   endtask

   initial begin
      #(WATCH_CYC * 4);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCH_CYC, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h1c0ffee));
      clear_inputs();
      eng_idle = 1; rd_idx = 0;
      for (int i = 0; i < N; i++) begin m_en[i] = 0; m_tx[i] = 0; m_len[i] = 0; m_ie[i] = 0; m_st[i] = 0; end
      m_gv = 0; m_gi = 0; prev_idle = 1;
      repeat (3) @(negedge clk);
      #1;
      chk(grant_valid == 0, "R1", "grant_valid after reset", int'(grant_valid), 0);
      chk(irq == 0, "R1", "irq after reset", int'(irq), 0);
      for (int i = 0; i < N; i++) begin
         read_obj(i);
         chk(rd_status == 0 && !rd_enable && rd_len == 0, "R1", $sformatf("obj %0d after reset", i),
             int'(rd_status), 0);
      end
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R3: several transmitters, lowest wins
      cfg(9, 1, 1, 3, 0);
      cfg(5, 1, 1, 2, 0);
      cfg(3, 1, 1, 1, 1);
      step();
      chk(grant_valid && grant_idx == 3, "R3", "lowest transmitter granted", int'(grant_idx), 3);
      // R4: frame in progress, lower transmitter appears, grant holds
      eng_idle = 0;
      cfg(1, 1, 1, 4, 0);
      step();
      chk(grant_idx == 3, "R4", "grant held during frame", int'(grant_idx), 3);
      // R8: both exclusions, then a real bit error
      bit_mismatch = 1; in_arbitration = 1; sent_recessive = 1; step();
      read_obj(3); chk(rd_status[4] == 0, "R8", "arbitration loss not a bit error", int'(rd_status[4]), 0);
      bit_mismatch = 1; errframe_ack = 1; step();
      read_obj(3); chk(rd_status[4] == 0, "R8", "error-frame ack not a bit error", int'(rd_status[4]), 0);
      bit_mismatch = 1; in_arbitration = 1; sent_recessive = 0; step();
      read_obj(3); chk(rd_status[4] == 1, "R8", "bit error raised", int'(rd_status[4]), 1);
      // R11 irq from object 3 flag
      chk(irq == 1, "R11", "irq with enabled flag", int'(irq), 1);
      // R10: clear write with a same-cycle stuff error set
      st_we = 1; st_idx = 3; st_data = 8'h00; stuff_err = 1; step();
      read_obj(3); chk(rd_status == 8'h08, "R10", "set wins over clear", int'(rd_status), 8);
      // R9 CRC, form, ack
      crc_err = 1; form_err = 1; ack_err = 1; step();
      read_obj(3); chk(rd_status == 8'h0F, "R9", "crc/form/ack flags", int'(rd_status), 15);
      // R5: completion
      tx_done = 1; step();
      read_obj(3); chk(rd_status[6] && !rd_enable, "R5", "tx ok and disarm", int'(rd_status), 8'h4F);
      eng_idle = 1; step(); step();
      chk(grant_idx == 1, "R3", "re-arbitration after idle", int'(grant_idx), 1);
      // R6/R7: multi-hit reception
      cfg(12, 1, 0, 8, 0);
      cfg(10, 1, 0, 8, 0);
      cfg(11, 1, 0, 5, 0);
      rx_eof6 = 1; rx_hit = 15'h1C00; rx_len = 2; step();
      read_obj(10); chk(rd_status == 8'hA0 && rd_len == 2, "R7", "lowest receiver with length warning", int'(rd_status), 8'hA0);
      read_obj(11); chk(rd_status == 0 && rd_enable, "R6", "second hit untouched", int'(rd_status), 0);
      rx_eof6 = 1; rx_hit = 15'h0800; rx_len = 5; step();
      read_obj(11); chk(rd_status == 8'h20, "R7", "equal length, no warning", int'(rd_status), 8'h20);
      // R2: configuration beats same-cycle reception
      rx_eof6 = 1; rx_hit = 15'h1000; rx_len = 1; cfg(12, 1, 0, 7, 1);
      read_obj(12); chk(rd_enable && rd_len == 7, "R2", "config wins over reception", int'(rd_len), 7);

      // random phase
      for (int c = 0; c < 3000; c++) begin
         eng_idle = ($urandom % 10) < 4;
         if (($urandom % 5) == 0) begin
            cfg_we = 1; cfg_idx = 4'($urandom % N); cfg_enable = ($urandom % 4) != 0;
            cfg_is_tx = $urandom % 2; cfg_len = 4'($urandom); cfg_irq_en = $urandom % 2;
         end
         if (($urandom % 7) == 0) begin
            st_we = 1; st_idx = 4'($urandom % N); st_data = ($urandom % 2) ? 8'h00 : 8'($urandom);
         end
         if (!eng_idle && ($urandom % 6) == 0) tx_done = 1;
         bit_mismatch = ($urandom % 16) == 0; sent_recessive = $urandom % 2;
         in_arbitration = $urandom % 2; errframe_ack = ($urandom % 4) == 0;
         stuff_err = ($urandom % 20) == 0; crc_err = ($urandom % 20) == 0;
         form_err = ($urandom % 20) == 0; ack_err = ($urandom % 20) == 0;
         if (($urandom % 6) == 0) begin
            rx_eof6 = 1; rx_hit = 15'($urandom); rx_len = 4'($urandom);
         end
         step();
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule